// File: doc/BRIEF.md
# Six-State Custom-Sequence Counter

This block is a 3-bit synchronous counter whose count does not follow binary order. It visits six codes in a fixed loop and returns to the start. The two codes outside the loop are never reached from inside it. The count is the stored state itself, so no decoding sits between the flip-flops and the output. Bit `count[2]` is the most significant state bit, `count[1]` is the middle bit and `count[0]` is the least significant bit.

The next state comes from minimised per-bit input equations, not from an adder. A parameter picks how the state is stored. In the data flip-flop build, each bit loads its equation directly. In the toggle build, each bit inverts when its equation is 1. Both builds produce the same loop. When a register starts in one of the two unused codes, it returns to the loop within two clocks.

Top module: `seqcnt6`

## Requirements
- R1: While `rst` is high at a rising clock edge, that edge sets `count` to 000. The reset is synchronous and active-high.
- R2: Starting from 000, each rising edge with `rst` low advances `count` along the loop 000, 011, 100, 101, 010, 001, and then back to 000.
- R3: Bit `count[0]` inverts on every rising edge that has `rst` low, in both builds and from any code.
- R4: From the unused code 110, one clock gives 101 in both builds.
- R5: In the data flip-flop build (`IMPL` = 0), the unused code 111 goes to 110 and then to 101.
- R6: In the toggle build (`IMPL` = 1), the unused code 111 goes to 000 after one clock.
- R7: Both builds give the same `count` at every clock while they run the main loop from the same reset.
- R8: Once `count` holds one of the six loop codes, it never moves to 110 or 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 000 |
| count | output | 3 | Current state and count value, with bit 2 as the MSB |

## Verification
The properties assume that `rst` and the clock are the only means of changing the state. The history-based checks therefore rely on no other event altering the register between two edges. The unused codes can only be reached by writing into the register from outside. The stimulus makes each such write in the same half-cycle in which reset is released. Every property that looks back one cycle sees reset active at that earlier edge and stays vacuous there. From the next edge on, the register evolves only through its own logic.

// File: rtl/scnt_pkg.sv
package scnt_pkg;

  // Storage flavour for the counter bits
  typedef enum logic {
    IMPL_D = 1'b0,
    IMPL_T = 1'b1
  } impl_e;

  localparam int unsigned SC_W = 3;

  // Named view of the state: a is the MSB, c the LSB
  typedef struct packed {
    logic a;
    logic b;
    logic c;
  } sc_bits_t;

  localparam logic [SC_W-1:0] SC_RESET = 3'b000;

endpackage

// File: rtl/scnt_dnext.sv
// Data flip-flop input equations (codes 110/111 were don't-cares)
module scnt_dnext
  import scnt_pkg::*;
(
  input  logic [SC_W-1:0] cur,
  output logic [SC_W-1:0] din
);

  sc_bits_t s;
  sc_bits_t n;

  always_comb begin
    s   = sc_bits_t'(cur);
    n.a = (s.a & ~s.c) | (s.b & s.c);
    n.b = (~s.a & ~s.b & ~s.c) | (s.a & s.c);
    n.c = ~s.c;
    din = n;
  end

endmodule

// File: rtl/scnt_tnext.sv
// Toggle flip-flop input equations: a bit flips when its input is 1
module scnt_tnext
  import scnt_pkg::*;
(
  input  logic [SC_W-1:0] cur,
  output logic [SC_W-1:0] tin
);

  sc_bits_t s;
  sc_bits_t n;

  always_comb begin
    s   = sc_bits_t'(cur);
    n.a = s.c & (s.a | s.b);
    n.b = (~s.a & ~s.c) | s.b | (s.a & s.c);
    n.c = 1'b1;
    tin = n;
  end

endmodule

// File: rtl/scnt_reg.sv
// State register; the flavour decides whether the input loads or toggles
module scnt_reg
  import scnt_pkg::*;
#(
  parameter impl_e IMPL = IMPL_D
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SC_W-1:0] ctl,
  output logic [SC_W-1:0] q
);

  logic [SC_W-1:0] q_r;

  generate
    if (IMPL == IMPL_T) begin : g_toggle
      always_ff @(posedge clk) begin
        if (rst) q_r <= SC_RESET;
        else     q_r <= q_r ^ ctl;
      end
    end else begin : g_load
      always_ff @(posedge clk) begin
        if (rst) q_r <= SC_RESET;
        else     q_r <= ctl;
      end
    end
  endgenerate

  assign q = q_r;

endmodule

// File: rtl/seqcnt6.sv
module seqcnt6
  import scnt_pkg::*;
#(
  parameter impl_e IMPL = IMPL_D
) (
  input  logic            clk,
  input  logic            rst,
  output logic [SC_W-1:0] count
);

  logic [SC_W-1:0] state;
  logic [SC_W-1:0] ctl;

  generate
    if (IMPL == IMPL_T) begin : g_tlogic
      scnt_tnext u_next (.cur(state), .tin(ctl));
    end else begin : g_dlogic
      scnt_dnext u_next (.cur(state), .din(ctl));
    end
  endgenerate

  scnt_reg #(.IMPL(IMPL)) u_reg (
    .clk (clk),
    .rst (rst),
    .ctl (ctl),
    .q   (state)
  );

  assign count = state;

endmodule

// File: rtl/seqcnt6_chk.sv
module seqcnt6_chk
  import scnt_pkg::*;
#(
  parameter impl_e IMPL = IMPL_D
) (
  input logic            clk,
  input logic            rst,
  input logic [SC_W-1:0] count
);

  function automatic logic in_loop(input logic [SC_W-1:0] v);
    return (v != 3'b110) && (v != 3'b111);
  endfunction

  function automatic logic [SC_W-1:0] loop_succ(input logic [SC_W-1:0] v);
    case (v)
      3'b000:  return 3'b011;
      3'b011:  return 3'b100;
      3'b100:  return 3'b101;
      3'b101:  return 3'b010;
      3'b010:  return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  AST_RESET_CLEARS: assert property (@(posedge clk)
    (rst && $past(rst)) |-> (count == 3'b000)); // R1

  AST_LOOP_STEP: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_loop(count)) |=> (count == loop_succ($past(count)))); // R2

  AST_LSB_FLIP: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (count[0] != $past(count[0]))); // R3

  AST_FIX_110: assert property (@(posedge clk) disable iff (rst)
    (!rst && count == 3'b110) |=> (count == 3'b101)); // R4

  generate
    if (IMPL == IMPL_T) begin : g_t_chk
      AST_FIX_111_T: assert property (@(posedge clk) disable iff (rst)
        (!rst && count == 3'b111) |=> (count == 3'b000)); // R6
    end else begin : g_d_chk
      AST_FIX_111_D: assert property (@(posedge clk) disable iff (rst)
        (!rst && count == 3'b111) |=> (count == 3'b110)); // R5
    end
  endgenerate

  AST_STAY_IN_LOOP: assert property (@(posedge clk) disable iff (rst)
    (!rst && in_loop(count)) |=> in_loop(count)); // R8

endmodule

bind seqcnt6 seqcnt6_chk #(.IMPL(IMPL)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .count (count)
);

// File: tb/seqcnt6_tb.sv
`timescale 1ns/1ps
module seqcnt6_tb;
  import scnt_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] cnt_d;
  logic [2:0] cnt_t;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  always #5 clk = ~clk;

  seqcnt6 #(.IMPL(IMPL_D)) u_dut   (.clk(clk), .rst(rst), .count(cnt_d));
  seqcnt6 #(.IMPL(IMPL_T)) u_dut_t (.clk(clk), .rst(rst), .count(cnt_t));

  // Two full loops plus the return to 000
  localparam logic [2:0] EXP_SEQ [0:12] = '{
    3'b000, 3'b011, 3'b100, 3'b101, 3'b010, 3'b001,
    3'b000, 3'b011, 3'b100, 3'b101, 3'b010, 3'b001, 3'b000
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Write an unused code into both registers while reset is released
  task automatic plant(input logic [2:0] code);
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    u_dut.u_reg.q_r   <= code;
    u_dut_t.u_reg.q_r <= code;
    @(negedge clk);
  endtask

  initial begin
    logic [2:0] prev_d;
    @(negedge clk);
    tick();
    tick();
    chk("R1", "reset D", cnt_d, 3'b000);
    chk("R1", "reset T", cnt_t, 3'b000);
    rst = 1'b0;

    for (int i = 1; i < 13; i++) begin
      prev_d = cnt_d;
      tick();
      chk("R2", "loop D", cnt_d, EXP_SEQ[i]);
      chk("R7", "T matches D", cnt_t, cnt_d);
      chk("R3", "LSB flip", {2'b00, cnt_d[0]}, {2'b00, ~prev_d[0]});
      chk("R8", "no unused code", {2'b00, cnt_d[2] & cnt_d[1]}, 3'b000);
    end

    // Reset in mid-loop
    tick();
    tick();
    chk("R2", "mid loop D", cnt_d, 3'b100);
    rst = 1'b1;
    tick();
    chk("R1", "mid reset D", cnt_d, 3'b000);
    chk("R1", "mid reset T", cnt_t, 3'b000);

    // 110 recovery
    plant(3'b110);
    chk("R4", "110 step1 D", cnt_d, 3'b101);
    chk("R4", "110 step1 T", cnt_t, 3'b101);
    tick();
    chk("R4", "110 step2 D", cnt_d, 3'b010);
    chk("R4", "110 step2 T", cnt_t, 3'b010);

    // 111 recovery
    plant(3'b111);
    chk("R5", "111 step1 D", cnt_d, 3'b110);
    chk("R6", "111 step1 T", cnt_t, 3'b000);
    chk("R3", "111 LSB T",   {2'b00, cnt_t[0]}, 3'b000);
    tick();
    chk("R5", "111 step2 D", cnt_d, 3'b101);
    chk("R6", "111 step2 T", cnt_t, 3'b011);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule